// File: doc/BRIEF.md
# Image Sensor Register Configuration Sequencer

This block brings an image sensor from reset to streaming. It walks a fixed list of register accesses. Each entry is a read or a write to a 16-bit sensor register, with a 16-bit data word. For every entry it hands one transaction to a byte-level I2C master through a start/done handshake, and it never has more than one transaction open at a time.

Between entries the sequencer inserts the waits the sensor needs. A settle time follows the write that powers up the sensor PLL. A short gap separates repeated status polls. The sequencer also checks two read-backs: the chip version word, and a status bit that shows the sensor has left standby.

A pulse on `go` starts the list at its first entry. The outputs `done`, `error`, `id_mismatch` and `fail_idx` report how the run ended. The bit-level I2C engine, pixel capture and any frame storage sit outside this block.

Top module: `cam_cfg_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `id_mismatch` and `m_start` are all low. A one-cycle `go` pulse while idle starts the run at entry 0, and `busy` is high while the run is in progress.
- R2: Transactions are issued in this fixed order.
  - Read 0x3000.
  - Write 0x3214=0x0D85.
  - Write 0x341E=0x8F0B, 0x341C=0x0250, 0x341E=0x8F09, 0x341E=0x8F08.
  - Write 0x3202=0x000C.
  - Read 0x3204.
  - Eight indirect variable writes. Each is a write of the variable address to 0x338C, followed by a write of the value to 0x3390. The pairs, as variable=value, are 0x2795=0x0030, 0x2719=0x046C, 0x2703=0x0280, 0x2705=0x01E0, 0x2751=0x0000, 0x2755=0x0000, 0x2753=0x0320, 0x2757=0x0258.
  - Write 0x3202=0x0008.
  - Write 0x301A=0x02CC.
  
  That is 26 entries, indexed 0 to 25.
- R3: `m_rw` is 1 for a read and 0 for a write. `m_dev` carries the bus address byte: 0x78 for writes and 0x79 for reads.
- R4: `m_start` is a single-cycle pulse. No new `m_start` occurs until `m_done` has answered the previous one.
- R5: After the acknowledged write 0x341E=0x8F09, the next `m_start` comes no sooner than SETTLE cycles after `m_done`, and no later than SETTLE+3 cycles. SETTLE equals CLK_HZ*SETTLE_US/10^6, rounded up. Every other write is followed by the next start within 3 cycles.
- R6: A chip-version read that returns anything other than 0x1580 sets `id_mismatch`. The sequence still runs on to completion.
- R7: The read of 0x3204 is repeated while bit 1 of the returned data is 1. There are at least POLL_GAP cycles between `m_done` and the next start. When bit 1 reads 0, the sequence moves to entry 8.
- R8: If POLL_MAX consecutive reads of 0x3204 all return bit 1 set, `error` rises, `fail_idx` becomes 7, and no further transaction is started.
- R9: A `m_done` with `m_nack` high on any entry ends the run. `error` rises, `done` stays low, `fail_idx` holds that entry's index, and no further `m_start` follows.
- R10: After the last entry is acknowledged, `done` is high and `busy` is low. `done` holds until the next `go`, and `done` and `error` are never high together.
- R11: A `go` pulse during a run has no effect. A `go` pulse after completion or failure restarts the run from entry 0, clearing `done`, `error`, `id_mismatch` and `fail_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Whole list acknowledged |
| error | output | 1 | Run aborted (NACK or poll limit) |
| id_mismatch | output | 1 | Chip version differed from 0x1580 |
| fail_idx | output | 5 | Index of the entry that aborted the run |
| m_start | output | 1 | Transaction request to the I2C master |
| m_dev | output | 8 | Bus address byte including the R/W bit |
| m_rw | output | 1 | 1 = read, 0 = write |
| m_reg | output | 16 | Sensor register address |
| m_wdata | output | 16 | Write data (expected value or mask on reads) |
| m_done | input | 1 | Transaction finished |
| m_nack | input | 1 | Transaction was not acknowledged (valid with m_done) |
| m_rdata | input | 16 | Read data (valid with m_done) |

## Verification
A responder answers every transaction after a fixed latency and logs each register access. This lets the whole list be compared, entry by entry, with a table held separately in the bench.

- Sweeping the number of busy status polls from zero up to the retry limit separates a correct repeat of entry 7 from both skipping and overrunning it. One further busy read then shows the poll-limit abort.
- A NACK is injected on each of the 26 entries in turn. This shows that the abort index, the stop of traffic and the restart all follow the failing position.
- A wrong chip version separates the mismatch flag from the error path.
- A `go` pulse in mid-run shows that the run is not restarted.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

  localparam int ENTRY_N = 26;
  localparam int IDX_W   = $clog2(ENTRY_N);
  localparam logic [6:0] SENSOR_ADDR7 = 7'h3C;
  localparam int POLL_IDX = 7;

  typedef enum logic [1:0] {CK_NONE, CK_EQ, CK_POLL} check_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_GAP, ST_FIN, ST_FAIL
  } seq_state_e;

  typedef struct packed {
    logic        rd;
    logic [15:0] reg_a;
    logic [15:0] val;
    logic        settle;
    check_e      ck;
  } cmd_t;

  function automatic cmd_t mk(input logic rd, input logic [15:0] a,
                              input logic [15:0] v, input logic s,
                              input check_e ck);
    cmd_t c;
    c.rd = rd; c.reg_a = a; c.val = v; c.settle = s; c.ck = ck;
    return c;
  endfunction

  // Ordered bring-up list; order matters (PLL ramp, standby exit, MCU restart).
  function automatic cmd_t cmd_at(input logic [IDX_W-1:0] i);
    case (int'(i))
      0:  return mk(1'b1, 16'h3000, 16'h1580, 1'b0, CK_EQ);
      1:  return mk(1'b0, 16'h3214, 16'h0D85, 1'b0, CK_NONE);
      2:  return mk(1'b0, 16'h341E, 16'h8F0B, 1'b0, CK_NONE);
      3:  return mk(1'b0, 16'h341C, 16'h0250, 1'b0, CK_NONE);
      4:  return mk(1'b0, 16'h341E, 16'h8F09, 1'b1, CK_NONE);
      5:  return mk(1'b0, 16'h341E, 16'h8F08, 1'b0, CK_NONE);
      6:  return mk(1'b0, 16'h3202, 16'h000C, 1'b0, CK_NONE);
      7:  return mk(1'b1, 16'h3204, 16'h0002, 1'b0, CK_POLL);
      8:  return mk(1'b0, 16'h338C, 16'h2795, 1'b0, CK_NONE);
      9:  return mk(1'b0, 16'h3390, 16'h0030, 1'b0, CK_NONE);
      10: return mk(1'b0, 16'h338C, 16'h2719, 1'b0, CK_NONE);
      11: return mk(1'b0, 16'h3390, 16'h046C, 1'b0, CK_NONE);
      12: return mk(1'b0, 16'h338C, 16'h2703, 1'b0, CK_NONE);
      13: return mk(1'b0, 16'h3390, 16'h0280, 1'b0, CK_NONE);
      14: return mk(1'b0, 16'h338C, 16'h2705, 1'b0, CK_NONE);
      15: return mk(1'b0, 16'h3390, 16'h01E0, 1'b0, CK_NONE);
      16: return mk(1'b0, 16'h338C, 16'h2751, 1'b0, CK_NONE);
      17: return mk(1'b0, 16'h3390, 16'h0000, 1'b0, CK_NONE);
      18: return mk(1'b0, 16'h338C, 16'h2755, 1'b0, CK_NONE);
      19: return mk(1'b0, 16'h3390, 16'h0000, 1'b0, CK_NONE);
      20: return mk(1'b0, 16'h338C, 16'h2753, 1'b0, CK_NONE);
      21: return mk(1'b0, 16'h3390, 16'h0320, 1'b0, CK_NONE);
      22: return mk(1'b0, 16'h338C, 16'h2757, 1'b0, CK_NONE);
      23: return mk(1'b0, 16'h3390, 16'h0258, 1'b0, CK_NONE);
      24: return mk(1'b0, 16'h3202, 16'h0008, 1'b0, CK_NONE);
      25: return mk(1'b0, 16'h301A, 16'h02CC, 1'b0, CK_NONE);
      default: return mk(1'b0, 16'h0000, 16'h0000, 1'b0, CK_NONE);
    endcase
  endfunction

  // Cycles for a wait of 'us' microseconds at 'hz', rounded up.
  function automatic int unsigned settle_cycles(input int unsigned hz,
                                                input int unsigned us);
    longint unsigned p;
    p = longint'(hz) * longint'(us);
    return int'((p + 64'd999999) / 64'd1000000);
  endfunction

  function automatic logic poll_pending(input logic [15:0] rdata,
                                        input logic [15:0] mask);
    return |(rdata & mask);
  endfunction

  function automatic logic [7:0] dev_byte(input logic rd);
    return {SENSOR_ADDR7, rd};
  endfunction

endpackage

// File: rtl/cam_cfg_rom.sv
module cam_cfg_rom
  import cam_cfg_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output cmd_t             cmd
);
  assign cmd = cmd_at(idx);
endmodule

// File: rtl/cam_cfg_timer.sv
module cam_cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         running
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign running = (cnt != '0);

  // An idle timer stays idle unless loaded (no spurious waits).
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> !running);
endmodule

// File: rtl/cam_cfg_chk.sv
module cam_cfg_chk
  import cam_cfg_pkg::*;
(
  input  cmd_t        cmd,
  input  logic [15:0] rdata,
  output logic        id_bad,
  output logic        poll_again
);
  always_comb begin
    id_bad     = cmd.rd && (cmd.ck == CK_EQ) && (rdata != cmd.val);
    poll_again = cmd.rd && (cmd.ck == CK_POLL) && poll_pending(rdata, cmd.val);
  end
endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq
  import cam_cfg_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_US = 1000,
  parameter int unsigned POLL_GAP  = 64,
  parameter int unsigned POLL_MAX  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             id_mismatch,
  output logic [IDX_W-1:0] fail_idx,
  output logic             m_start,
  output logic [7:0]       m_dev,
  output logic             m_rw,
  output logic [15:0]      m_reg,
  output logic [15:0]      m_wdata,
  input  logic             m_done,
  input  logic             m_nack,
  input  logic [15:0]      m_rdata
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);
  localparam int unsigned TMAX  = (SETTLE_CYC > POLL_GAP) ? SETTLE_CYC : POLL_GAP;
  localparam int          TW    = $clog2(TMAX + 1);
  localparam int          TRY_W = $clog2(POLL_MAX + 1);

  seq_state_e       st;
  logic [IDX_W-1:0] idx;
  logic [TRY_W-1:0] tries;
  logic             adv;
  cmd_t             cmd;
  logic             id_bad, poll_again, tmr_run;

  cam_cfg_rom u_rom (.idx(idx), .cmd(cmd));
  cam_cfg_chk u_chk (.cmd(cmd), .rdata(m_rdata), .id_bad(id_bad), .poll_again(poll_again));

  // Named internal events
  logic ev_ack_ok, ev_ack_bad, ev_retry, ev_exhaust, ev_hold, ev_settle;
  logic ev_gap_end, ev_step, ev_last, ev_restart;
  logic             tload;
  logic [TW-1:0]    tval;

  always_comb begin
    ev_ack_ok  = (st == ST_WAIT) && m_done && !m_nack;
    ev_ack_bad = (st == ST_WAIT) && m_done && m_nack;
    ev_retry   = ev_ack_ok && poll_again;
    ev_exhaust = ev_retry && (tries == TRY_W'(POLL_MAX - 1));
    ev_hold    = ev_retry && !ev_exhaust;
    ev_settle  = ev_ack_ok && !poll_again && cmd.settle;
    ev_gap_end = (st == ST_GAP) && !tmr_run;
    ev_step    = (ev_ack_ok && !poll_again && !cmd.settle) || (ev_gap_end && adv);
    ev_last    = (idx == IDX_W'(ENTRY_N - 1));
    ev_restart = go && ((st == ST_IDLE) || (st == ST_FIN) || (st == ST_FAIL));
    tload      = ev_hold || ev_settle;
    tval       = ev_hold ? TW'(POLL_GAP) : TW'(SETTLE_CYC);
  end

  cam_cfg_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .running(tmr_run)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      idx         <= '0;
      tries       <= '0;
      adv         <= 1'b0;
      id_mismatch <= 1'b0;
      fail_idx    <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_FIN, ST_FAIL: begin
          if (ev_restart) begin
            st          <= ST_ISSUE;
            idx         <= '0;
            tries       <= '0;
            id_mismatch <= 1'b0;
            fail_idx    <= '0;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (ev_ack_bad) begin
            st       <= ST_FAIL;
            fail_idx <= idx;
          end else if (ev_ack_ok) begin
            if (id_bad) id_mismatch <= 1'b1;
            if (ev_exhaust) begin
              st       <= ST_FAIL;
              fail_idx <= idx;
            end else if (ev_hold) begin
              tries <= tries + 1'b1;
              adv   <= 1'b0;
              st    <= ST_GAP;
            end else if (ev_settle) begin
              adv <= 1'b1;
              st  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (ev_gap_end && !adv) st <= ST_ISSUE;
        end
        default: st <= ST_IDLE;
      endcase
      if (ev_step) begin
        tries <= '0;
        if (ev_last) st <= ST_FIN;
        else begin
          idx <= idx + 1'b1;
          st  <= ST_ISSUE;
        end
      end
    end
  end

  assign busy    = (st == ST_ISSUE) || (st == ST_WAIT) || (st == ST_GAP);
  assign done    = (st == ST_FIN);
  assign error   = (st == ST_FAIL);
  assign m_start = (st == ST_ISSUE);
  assign m_rw    = cmd.rd;
  assign m_dev   = dev_byte(cmd.rd);
  assign m_reg   = cmd.reg_a;
  assign m_wdata = cmd.val;

  // ---------------- assertions ----------------
  logic        pend_q;
  logic        settle_armed;
  logic [31:0] since_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      settle_armed <= 1'b0;
      since_done   <= '0;
    end else begin
      if (m_start)     pend_q <= 1'b1;
      else if (m_done) pend_q <= 1'b0;
      if (m_done) begin
        since_done   <= '0;
        settle_armed <= !m_nack && cmd.settle && !cmd.rd;
      end else begin
        if (since_done != 32'hFFFF_FFFF) since_done <= since_done + 1'b1;
        if (m_start) settle_armed <= 1'b0;
      end
    end
  end

  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_start |-> !pend_q);
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_start |=> !m_start);
  assert_settle_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_start && settle_armed) |-> (since_done >= SETTLE_CYC));
  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries < TRY_W'(POLL_MAX)));
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !go) |=> (error && !m_start));
  assert_end_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_busy_ignores_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && !m_done) |=> $stable(idx));

endmodule

// File: tb/cam_cfg_seq_test.sv
module cam_cfg_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ = 200_000;
  localparam int unsigned US = 1000;
  localparam int unsigned PGAP = 6;
  localparam int unsigned PMAX = 4;
  localparam int LAT = 3;
  localparam int N_ENT = 26;
  localparam int SETTLE_EXP = HZ / 1000 * US / 1000;

  logic clk = 0, rst_n = 0, go = 0;
  logic busy, done, error, id_mismatch, m_start, m_rw;
  logic [4:0] fail_idx;
  logic [7:0] m_dev;
  logic [15:0] m_reg, m_wdata, m_rdata;
  logic m_done = 0, m_nack = 0;

  cam_cfg_seq #(.CLK_HZ(HZ), .SETTLE_US(US), .POLL_GAP(PGAP), .POLL_MAX(PMAX)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .error(error),
    .id_mismatch(id_mismatch), .fail_idx(fail_idx), .m_start(m_start), .m_dev(m_dev),
    .m_rw(m_rw), .m_reg(m_reg), .m_wdata(m_wdata), .m_done(m_done), .m_nack(m_nack),
    .m_rdata(m_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // responder config and log
  logic [15:0] cfg_chip = 16'h1580;
  int cfg_polls = 0;
  bit cfg_forever = 0;
  int cfg_nack_at = -1;
  int txn = 0, viol = 0, ncyc = 0, last_done = 0;
  int gap_settle = -1, min_poll_gap = 1 << 30, max_plain_gap = 0;
  int poll_left = 0;
  bit pend = 0, prev_settle = 0, prev_poll = 0;
  int lat_cnt = 0;
  logic        log_rw  [0:63];
  logic [15:0] log_reg [0:63];
  logic [15:0] log_dat [0:63];
  logic [7:0]  log_dev [0:63];
  logic        cur_rw;
  logic [15:0] cur_reg, cur_dat;

  always @(negedge clk) begin
    ncyc++;
    m_done = 0; m_nack = 0;
    if (m_start && pend) viol++;
    if (pend) begin
      if (lat_cnt == 0) begin
        m_done = 1;
        m_nack = (txn - 1 == cfg_nack_at);
        m_rdata = 16'h0000;
        prev_poll = 0;
        if (cur_rw && cur_reg == 16'h3000) m_rdata = cfg_chip;
        if (cur_rw && cur_reg == 16'h3204) begin
          if (cfg_forever || poll_left > 0) begin
            m_rdata = 16'h0002; poll_left--; prev_poll = !m_nack;
          end
        end
        prev_settle = !m_nack && !cur_rw && cur_reg == 16'h341E && cur_dat == 16'h8F09;
        last_done = ncyc;
        pend = 0;
      end else lat_cnt--;
    end
    if (m_start) begin
      if (txn > 0) begin
        if (prev_settle) gap_settle = ncyc - last_done;
        else if (prev_poll) begin
          if (ncyc - last_done < min_poll_gap) min_poll_gap = ncyc - last_done;
        end else if (ncyc - last_done > max_plain_gap) max_plain_gap = ncyc - last_done;
      end
      if (txn < 64) begin
        log_rw[txn] = m_rw; log_reg[txn] = m_reg; log_dat[txn] = m_wdata; log_dev[txn] = m_dev;
      end
      cur_rw = m_rw; cur_reg = m_reg; cur_dat = m_wdata;
      txn++;
      pend = 1;
      lat_cnt = LAT;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench copy of the required list: {rd, reg, data}
  function automatic logic [32:0] exp_cmd(input int e);
    logic [15:0] vaddr [0:7];
    logic [15:0] vval  [0:7];
    vaddr = '{16'h2795, 16'h2719, 16'h2703, 16'h2705, 16'h2751, 16'h2755, 16'h2753, 16'h2757};
    vval  = '{16'h0030, 16'h046C, 16'h0280, 16'h01E0, 16'h0000, 16'h0000, 16'h0320, 16'h0258};
    if (e >= 8 && e <= 23) begin
      if ((e - 8) % 2 == 0) return {1'b0, 16'h338C, vaddr[(e-8)/2]};
      else                  return {1'b0, 16'h3390, vval[(e-8)/2]};
    end
    case (e)
      0: return {1'b1, 16'h3000, 16'h0000};
      1: return {1'b0, 16'h3214, 16'h0D85};
      2: return {1'b0, 16'h341E, 16'h8F0B};
      3: return {1'b0, 16'h341C, 16'h0250};
      4: return {1'b0, 16'h341E, 16'h8F09};
      5: return {1'b0, 16'h341E, 16'h8F08};
      6: return {1'b0, 16'h3202, 16'h000C};
      7: return {1'b1, 16'h3204, 16'h0000};
      24: return {1'b0, 16'h3202, 16'h0008};
      default: return {1'b0, 16'h301A, 16'h02CC};
    endcase
  endfunction

  task automatic run(input logic [15:0] chip, input int polls, input bit forever_busy,
                     input int nack_at, input bit mid_go);
    int t;
    cfg_chip = chip; cfg_polls = polls; poll_left = polls; cfg_forever = forever_busy;
    cfg_nack_at = nack_at; txn = 0; gap_settle = -1; min_poll_gap = 1 << 30;
    max_plain_gap = 0; prev_settle = 0; prev_poll = 0;
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    if (mid_go) begin
      t = 0;
      while (txn < 10 && t < 5000) begin @(negedge clk); t++; end
      go = 1; @(negedge clk); go = 0;
    end
    t = 0;
    while (!(done || error) && t < 20000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
  endtask

  task automatic check_list(input int polls, input string tag);
    int e;
    logic [32:0] x;
    for (int j = 0; j < N_ENT + polls; j++) begin
      e = (j < 8) ? j : ((j < 8 + polls) ? 7 : j - polls);
      x = exp_cmd(e);
      check(log_rw[j] == x[32] && log_reg[j] == x[31:16] && (x[32] || log_dat[j] == x[15:0]),
            tag, {log_rw[j], log_reg[j], log_dat[j]}, x);
      check(log_dev[j] == (x[32] ? 8'h79 : 8'h78), "R3 device byte", log_dev[j], x[32] ? 8'h79 : 8'h78);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !id_mismatch && !m_start, "R1 reset state",
          {busy, done, error, id_mismatch, m_start}, 0);

    // nominal run with two busy polls
    run(16'h1580, 2, 0, -1, 0);
    check(txn == N_ENT + 2, "R2 transaction count", txn, N_ENT + 2);
    check_list(2, "R2 entry order/content");
    check(viol == 0, "R4 overlapping start", viol, 0);
    check(gap_settle >= SETTLE_EXP && gap_settle <= SETTLE_EXP + 3, "R5 settle gap", gap_settle, SETTLE_EXP);
    check(max_plain_gap <= 3, "R5 plain gap", max_plain_gap, 3);
    check(min_poll_gap >= PGAP, "R7 poll gap", min_poll_gap, PGAP);
    check(done && !error && !busy, "R10 done state", {done, error, busy}, 3'b100);
    check(!id_mismatch, "R6 good id", id_mismatch, 0);
    repeat (30) @(negedge clk);
    check(done && !m_start, "R10 done held", done, 1);

    // R7 sweep of busy poll counts
    for (int p = 0; p < PMAX; p++) begin
      run(16'h1580, p, 0, -1, 0);
      check(txn == N_ENT + p && done && !error, "R7 poll sweep count", txn, N_ENT + p);
      check_list(p, "R7 poll sweep order");
    end

    // R6 wrong chip id
    run(16'h1581, 0, 0, -1, 0);
    check(id_mismatch && done && !error, "R6 mismatch flagged, run completes",
          {id_mismatch, done, error}, 3'b110);
    run(16'h1580, 0, 0, -1, 0);
    check(!id_mismatch && done, "R11 restart clears mismatch", id_mismatch, 0);

    // R8 poll never clears
    run(16'h1580, 0, 1, -1, 0);
    check(error && !done && fail_idx == 7, "R8 poll limit abort", {error, done, fail_idx}, {2'b10, 5'd7});
    check(txn == 7 + PMAX, "R8 poll read count", txn, 7 + PMAX);

    // R9 NACK sweep over every entry
    for (int k = 0; k < N_ENT; k++) begin
      run(16'h1580, 0, 0, k, 0);
      check(error && !done && !busy, "R9 nack abort state", {error, done, busy}, 3'b100);
      check(fail_idx == 5'(k), "R9 fail index", fail_idx, k);
      check(txn == k + 1, "R9 no traffic after nack", txn, k + 1);
      check(log_reg[0] == 16'h3000, "R11 restart at entry 0", log_reg[0], 16'h3000);
      check(viol == 0, "R4 overlapping start", viol, 0);
    end

    // R11 go during a run is ignored
    run(16'h1580, 1, 0, -1, 1);
    check(txn == N_ENT + 1 && done && fail_idx == 0, "R11 mid-run go ignored", txn, N_ENT + 1);
    check_list(1, "R11 order after mid-run go");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule